// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits at the issue stage of an out-of-order core. It chooses up to `ISSUE_W` instructions per cycle from six class-specific ready buffers: integer, floating point, branch, memory, miscellaneous, and a drain list that holds cancelled instructions waiting to be flushed. The buffers are outside the block. Each buffer shows its first `WIN` entries to the selector, oldest at index 0. Every entry carries a valid bit, a squashed flag and a sequence number. Within a window the valid entries are contiguous from index 0.

Selection is an unrolled chain of identical steps. Each step first discards any squashed entries at the front of every class that can still issue. It then gives the next output slot to the oldest remaining front entry. The block reports a per-class pop count in the same cycle, and the buffers retire that many entries at the clock edge. The chosen instructions are written into a registered issue latch. That latch also raises a notification toward the memory-ordering logic whenever a memory instruction issues.

Class codes on `slot_cls` are: 0 integer, 1 float, 2 branch, 3 memory, 4 miscellaneous, 5 drain. For packed vectors, the bit index of class `c`, window entry `w` is `c*WIN+w`. Sequence numbers sit at `(c*WIN+w)*SEQ_W`. Pop counts sit at `c*PTR_W`, where `PTR_W = $clog2(WIN+1)`. Slot `s` occupies `s*3` in `slot_cls` and `s*SEQ_W` in `slot_seq`.

Top module: `isq_oldest_select`

## Requirements
- R1: No more than `ISSUE_W` instructions issue in one cycle. Once `ISSUE_W` have been chosen, no further entry of any class is popped in that cycle, squashed or not.
- R2: Per-cycle class limits apply: integer at most `INT_W`, float at most `FP_W`, branch at most 1, memory at most 1. Miscellaneous and drain have no limit beyond the total width.
- R3: Each slot goes to the front entry with the smallest sequence number among classes still under their limit, compared as unsigned numbers. On equal sequence numbers the class with the lower code (0 to 5) wins.
- R4: In classes 0 to 4, squashed entries at the front of a class that is still under its limit are popped and discarded without taking a slot. Selection then continues with the next entry of that class.
- R5: Entries of the drain list (class 5) ignore the squashed flag. They issue by age like any other entry and count only against the total width.
- R6: Issued instructions fill slots contiguously from slot 0. Each filled slot carries the class code and the sequence number. Unused slots have `slot_valid` low.
- R7: `pop_cnt` for each class equals the number of window entries that class consumed this cycle (issued plus discarded). It is combinational from the inputs of the same cycle and is 0 when no entry is valid.
- R8: The slot outputs and `mem_notify` are registered and show the selection made in the previous cycle. `mem_notify` is high exactly when one of those slots holds a memory instruction.
- R9: While `rst_n` is low, every `slot_valid` bit and `mem_notify` are held low.
- R10: A class that reaches its limit in a cycle leaves any further entries unpopped, including squashed ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the issue latch |
| hd_valid | input | 6*WIN | Valid bit per class window entry |
| hd_squash | input | 6*WIN | Squashed flag per class window entry (ignored for drain) |
| hd_seq | input | 6*WIN*SEQ_W | Sequence number per class window entry |
| pop_cnt | output | 6*PTR_W | Entries each class consumes this cycle |
| slot_valid | output | ISSUE_W | Registered issue slot valid |
| slot_cls | output | ISSUE_W*3 | Registered class code per slot |
| slot_seq | output | ISSUE_W*SEQ_W | Registered sequence number per slot |
| mem_notify | output | 1 | Registered pulse: a memory instruction issued |

## Verification
Two functions often act in the same cycle: discarding squashed entries and filling slots by age. The hardest cases are when a squashed entry sits in front of an older live entry, and when a class limit or the total width is reached before a squashed entry is examined. Random windows with about a third of entries squashed and narrow sequence ranges produce many such overlaps, plus frequent ties. Directed vectors pin down the exhausted-limit, tie-break and drain cases. For every vector, the pop counts are compared in the same cycle and the slots after the edge, against a bench model. That model restarts its scan after each discard instead of skipping runs.

// File: rtl/isq_pkg.sv
package isq_pkg;

  localparam int NCLS  = 6;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 3'd0,
    CLS_FP    = 3'd1,
    CLS_BR    = 3'd2,
    CLS_MEM   = 3'd3,
    CLS_MISC  = 3'd4,
    CLS_DRAIN = 3'd5
  } iclass_e;

  // Per-cycle issue limit of a class; uncapped classes get the total width.
  function automatic int unsigned class_cap(input int unsigned c, input int unsigned int_w,
                                            input int unsigned fp_w, input int unsigned total_w);
    case (c)
      0:       return int_w;
      1:       return fp_w;
      2, 3:    return 1;
      default: return total_w;
    endcase
  endfunction

  // Only the drain list issues squashed entries instead of discarding them.
  function automatic logic drops_squashed(input int unsigned c);
    return c != int'(CLS_DRAIN);
  endfunction

endpackage

// File: rtl/isq_pick_step.sv
module isq_pick_step
  import isq_pkg::*;
#(
  parameter int WIN     = 4,
  parameter int SEQ_W   = 8,
  parameter int INT_W   = 2,
  parameter int FP_W    = 1,
  parameter int ISSUE_W = 4,
  parameter int PTR_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic                                 active_i,
  input  logic [NCLS-1:0][WIN-1:0]             vld_i,
  input  logic [NCLS-1:0][WIN-1:0]             sq_i,
  input  logic [NCLS-1:0][WIN-1:0][SEQ_W-1:0]  seq_i,
  input  logic [NCLS-1:0][PTR_W-1:0]           ptr_i,
  input  logic [NCLS-1:0][CNT_W-1:0]           cnt_i,
  output logic [NCLS-1:0][PTR_W-1:0]           ptr_o,
  output logic [NCLS-1:0][CNT_W-1:0]           cnt_o,
  output logic                                 issued_o,
  output logic [CLS_W-1:0]                     cls_o,
  output logic [SEQ_W-1:0]                     seq_o
);

  // First index at or after p that is not a valid squashed entry.
  function automatic logic [PTR_W-1:0] skip_run(input logic [WIN-1:0] v, input logic [WIN-1:0] s,
                                                input logic [PTR_W-1:0] p);
    logic [PTR_W-1:0] n;
    n = p;
    for (int w = 0; w < WIN; w++)
      if (PTR_W'(w) == n && v[w] && s[w]) n = PTR_W'(w + 1);
    return n;
  endfunction

  function automatic logic bit_at(input logic [WIN-1:0] v, input logic [PTR_W-1:0] p);
    logic r;
    r = 1'b0;
    for (int w = 0; w < WIN; w++)
      if (PTR_W'(w) == p) r = v[w];
    return r;
  endfunction

  function automatic logic [SEQ_W-1:0] seq_at(input logic [WIN-1:0][SEQ_W-1:0] s,
                                              input logic [PTR_W-1:0] p);
    logic [SEQ_W-1:0] r;
    r = '0;
    for (int w = 0; w < WIN; w++)
      if (PTR_W'(w) == p) r = s[w];
    return r;
  endfunction

  logic [NCLS-1:0]                  elig;
  logic [NCLS-1:0]                  cand;
  logic [NCLS-1:0][PTR_W-1:0]       head_ptr;
  logic [NCLS-1:0][SEQ_W-1:0]       cand_seq;
  logic                             found;
  logic [CLS_W-1:0]                 win_cls;
  logic [SEQ_W-1:0]                 best_seq;

  // Per class: limit check, squash skipping, front entry lookup.
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      elig[c]     = active_i &&
                    (cnt_i[c] < CNT_W'(class_cap(c, INT_W, FP_W, ISSUE_W)));
      head_ptr[c] = (elig[c] && drops_squashed(c)) ? skip_run(vld_i[c], sq_i[c], ptr_i[c])
                                                   : ptr_i[c];
      cand[c]     = elig[c] && bit_at(vld_i[c], head_ptr[c]);
      cand_seq[c] = seq_at(seq_i[c], head_ptr[c]);
    end
  end

  // Oldest candidate; lower class code wins ties (strict compare).
  always_comb begin
    found    = 1'b0;
    win_cls  = '0;
    best_seq = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (cand[c] && (!found || cand_seq[c] < best_seq)) begin
        found    = 1'b1;
        win_cls  = CLS_W'(c);
        best_seq = cand_seq[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      ptr_o[c] = head_ptr[c];
      cnt_o[c] = cnt_i[c];
      if (found && win_cls == CLS_W'(c)) begin
        ptr_o[c] = head_ptr[c] + PTR_W'(1);
        cnt_o[c] = cnt_i[c] + CNT_W'(1);
      end
    end
    issued_o = found;
    cls_o    = win_cls;
    seq_o    = best_seq;
  end

endmodule

// File: rtl/isq_issue_latch.sv
module isq_issue_latch
  import isq_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int SEQ_W   = 8,
  parameter int INT_W   = 2,
  parameter int FP_W    = 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ISSUE_W-1:0]                  sel_valid,
  input  logic [ISSUE_W-1:0][CLS_W-1:0]       sel_cls,
  input  logic [ISSUE_W-1:0][SEQ_W-1:0]       sel_seq,
  output logic [ISSUE_W-1:0]                  q_valid,
  output logic [ISSUE_W-1:0][CLS_W-1:0]       q_cls,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]       q_seq,
  output logic                                q_mem
);

  function automatic logic has_class(input logic [ISSUE_W-1:0] v,
                                     input logic [ISSUE_W-1:0][CLS_W-1:0] k, input iclass_e c);
    logic r;
    r = 1'b0;
    for (int s = 0; s < ISSUE_W; s++) r = r | (v[s] && k[s] == c);
    return r;
  endfunction

  logic mem_pick;
  assign mem_pick = has_class(sel_valid, sel_cls, CLS_MEM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= '0;
      q_cls   <= '0;
      q_seq   <= '0;
      q_mem   <= 1'b0;
    end else begin
      q_valid <= sel_valid;
      q_cls   <= sel_cls;
      q_seq   <= sel_seq;
      q_mem   <= mem_pick;
    end
  end

  // Named per-slot class events for the checks below.
  logic [ISSUE_W-1:0] slot_is_int, slot_is_fp, slot_is_br, slot_is_mem;
  always_comb begin
    for (int s = 0; s < ISSUE_W; s++) begin
      slot_is_int[s] = q_valid[s] && q_cls[s] == CLS_INT;
      slot_is_fp[s]  = q_valid[s] && q_cls[s] == CLS_FP;
      slot_is_br[s]  = q_valid[s] && q_cls[s] == CLS_BR;
      slot_is_mem[s] = q_valid[s] && q_cls[s] == CLS_MEM;
    end
  end

  p_int_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_is_int) <= INT_W);
  p_fp_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_is_fp) <= FP_W);
  p_branch_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_is_br));
  p_mem_notify_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_mem == ($countones(slot_is_mem) == 1));
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (q_valid == '0 && !q_mem));

endmodule

// File: rtl/isq_oldest_select.sv
module isq_oldest_select
  import isq_pkg::*;
#(
  parameter int WIN     = 4,
  parameter int SEQ_W   = 8,
  parameter int ISSUE_W = 4,
  parameter int INT_W   = 2,
  parameter int FP_W    = 1,
  localparam int PTR_W  = $clog2(WIN + 1),
  localparam int CNT_W  = $clog2(ISSUE_W + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NCLS*WIN-1:0]             hd_valid,
  input  logic [NCLS*WIN-1:0]             hd_squash,
  input  logic [NCLS*WIN*SEQ_W-1:0]       hd_seq,
  output logic [NCLS*PTR_W-1:0]           pop_cnt,
  output logic [ISSUE_W-1:0]              slot_valid,
  output logic [ISSUE_W*CLS_W-1:0]        slot_cls,
  output logic [ISSUE_W*SEQ_W-1:0]        slot_seq,
  output logic                            mem_notify
);

  logic [NCLS-1:0][WIN-1:0]             vld_a, sq_a;
  logic [NCLS-1:0][WIN-1:0][SEQ_W-1:0]  seq_a;
  assign vld_a = hd_valid;
  assign sq_a  = hd_squash;
  assign seq_a = hd_seq;

  logic [ISSUE_W:0][NCLS-1:0][PTR_W-1:0] ptr_ch;
  logic [ISSUE_W:0][NCLS-1:0][CNT_W-1:0] cnt_ch;
  logic [ISSUE_W:0]                      act_ch;
  logic [ISSUE_W-1:0]                    sel_valid;
  logic [ISSUE_W-1:0][CLS_W-1:0]         sel_cls;
  logic [ISSUE_W-1:0][SEQ_W-1:0]         sel_seq;

  assign ptr_ch[0] = '0;
  assign cnt_ch[0] = '0;
  assign act_ch[0] = 1'b1;

  // One step per slot; a step that finds nothing stops the chain.
  for (genvar s = 0; s < ISSUE_W; s++) begin : g_step
    isq_pick_step #(
      .WIN(WIN), .SEQ_W(SEQ_W), .INT_W(INT_W), .FP_W(FP_W),
      .ISSUE_W(ISSUE_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_step (
      .active_i (act_ch[s]),
      .vld_i    (vld_a),
      .sq_i     (sq_a),
      .seq_i    (seq_a),
      .ptr_i    (ptr_ch[s]),
      .cnt_i    (cnt_ch[s]),
      .ptr_o    (ptr_ch[s+1]),
      .cnt_o    (cnt_ch[s+1]),
      .issued_o (sel_valid[s]),
      .cls_o    (sel_cls[s]),
      .seq_o    (sel_seq[s])
    );
    assign act_ch[s+1] = sel_valid[s];
  end

  assign pop_cnt = ptr_ch[ISSUE_W];

  logic [ISSUE_W-1:0][CLS_W-1:0] q_cls;
  logic [ISSUE_W-1:0][SEQ_W-1:0] q_seq;

  isq_issue_latch #(
    .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .INT_W(INT_W), .FP_W(FP_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_valid (sel_valid),
    .sel_cls   (sel_cls),
    .sel_seq   (sel_seq),
    .q_valid   (slot_valid),
    .q_cls     (q_cls),
    .q_seq     (q_seq),
    .q_mem     (mem_notify)
  );

  assign slot_cls = q_cls;
  assign slot_seq = q_seq;

  // Slots fill from 0 without holes.
  for (genvar s = 0; s + 1 < ISSUE_W; s++) begin : g_contig
    p_slot_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[s+1] |-> slot_valid[s]);
  end

  p_idle_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid == '0) |-> (pop_cnt == '0));

  p_idle_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid == '0) |=> (slot_valid == '0));

endmodule

// File: tb/tb_isq_oldest_select.sv
`timescale 1ns/1ps
module tb_isq_oldest_select;

  localparam int WIN = 4, SEQ_W = 8, ISSUE_W = 4, INT_W = 2, FP_W = 1;
  localparam int NC = 6, PW = 3, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC*WIN-1:0]        hd_valid = '0, hd_squash = '0;
  logic [NC*WIN*SEQ_W-1:0]  hd_seq = '0;
  logic [NC*PW-1:0]         pop_cnt;
  logic [ISSUE_W-1:0]       slot_valid;
  logic [ISSUE_W*CW-1:0]    slot_cls;
  logic [ISSUE_W*SEQ_W-1:0] slot_seq;
  logic                     mem_notify;

  always #2 clk = ~clk;

  isq_oldest_select #(.WIN(WIN), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W), .INT_W(INT_W), .FP_W(FP_W)) dut (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_squash(hd_squash), .hd_seq(hd_seq),
    .pop_cnt(pop_cnt), .slot_valid(slot_valid), .slot_cls(slot_cls), .slot_seq(slot_seq),
    .mem_notify(mem_notify));

  int tests = 0, fails = 0;
  bit done = 0;

  // Stimulus arrays and expected results.
  bit v[NC][WIN], q[NC][WIN];
  int sq_n[NC][WIN];
  int e_pop[NC];
  bit e_sv[ISSUE_W];
  int e_cls[ISSUE_W], e_seq[ISSUE_W];
  bit e_mem;

  function automatic int limit_of(int c);
    if (c == 0) return INT_W;
    if (c == 1) return FP_W;
    if (c == 2 || c == 3) return 1;
    return ISSUE_W;
  endfunction

  // Scan restarts after every discard; stops at width or when nothing is eligible.
  task automatic model();
    int ptr[NC], cnt[NC], total, best, bseq;
    bit restart;
    for (int c = 0; c < NC; c++) begin ptr[c] = 0; cnt[c] = 0; end
    for (int s = 0; s < ISSUE_W; s++) begin e_sv[s] = 0; e_cls[s] = 0; e_seq[s] = 0; end
    e_mem = 0; total = 0;
    while (total < ISSUE_W) begin
      restart = 0; best = -1; bseq = 0;
      for (int c = 0; c < NC; c++) begin
        if (cnt[c] < limit_of(c) && ptr[c] < WIN && v[c][ptr[c]]) begin
          if (c != 5 && q[c][ptr[c]]) begin ptr[c]++; restart = 1; break; end
          if (best < 0 || sq_n[c][ptr[c]] < bseq) begin best = c; bseq = sq_n[c][ptr[c]]; end
        end
      end
      if (restart) continue;
      if (best < 0) break;
      e_sv[total] = 1; e_cls[total] = best; e_seq[total] = bseq;
      if (best == 3) e_mem = 1;
      ptr[best]++; cnt[best]++; total++;
    end
    for (int c = 0; c < NC; c++) e_pop[c] = ptr[c];
  endtask

  task automatic clear_arrays();
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < WIN; w++) begin v[c][w] = 0; q[c][w] = 0; sq_n[c][w] = 0; end
  endtask

  task automatic load(int c, int n, int seq0, int sqmask);
    for (int w = 0; w < n; w++) begin
      v[c][w] = 1; sq_n[c][w] = seq0 + w; q[c][w] = sqmask[w];
    end
  endtask

  task automatic fail_line(string what, int got, int exp);
    fails++;
    $display("FAIL %s: got %0d expected %0d", what, got, exp);
  endtask

  // Drive, check pops in the same cycle, then check slots after the edge.
  task automatic run_vec(string tag);
    bit bad;
    model();
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < WIN; w++) begin
        hd_valid[c*WIN+w]  = v[c][w];
        hd_squash[c*WIN+w] = q[c][w];
        hd_seq[(c*WIN+w)*SEQ_W +: SEQ_W] = SEQ_W'(sq_n[c][w]);
      end
    #1;
    tests++; bad = 0;
    for (int c = 0; c < NC; c++)
      if (!bad && int'(pop_cnt[c*PW +: PW]) != e_pop[c]) begin
        bad = 1;
        fail_line($sformatf("%s pop class %0d", tag, c), int'(pop_cnt[c*PW +: PW]), e_pop[c]);
      end
    @(posedge clk); #1;
    tests++; bad = 0;
    for (int s = 0; s < ISSUE_W; s++) begin
      if (!bad && slot_valid[s] != e_sv[s]) begin
        bad = 1; fail_line($sformatf("%s slot %0d valid", tag, s), int'(slot_valid[s]), int'(e_sv[s]));
      end
      if (!bad && e_sv[s] && int'(slot_cls[s*CW +: CW]) != e_cls[s]) begin
        bad = 1; fail_line($sformatf("%s slot %0d class", tag, s), int'(slot_cls[s*CW +: CW]), e_cls[s]);
      end
      if (!bad && e_sv[s] && int'(slot_seq[s*SEQ_W +: SEQ_W]) != e_seq[s]) begin
        bad = 1; fail_line($sformatf("%s slot %0d seq", tag, s), int'(slot_seq[s*SEQ_W +: SEQ_W]), e_seq[s]);
      end
    end
    if (!bad && mem_notify != e_mem) fail_line({tag, " R8 mem_notify"}, int'(mem_notify), int'(e_mem));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clear_arrays();
    // R9: reset holds slots and notify low even with busy inputs.
    hd_valid = '1; hd_seq = '0;
    repeat (3) @(posedge clk);
    #1; tests++;
    if (slot_valid != '0 || mem_notify) fail_line("R9 reset outputs", int'({slot_valid, mem_notify}), 0);
    hd_valid = '0;
    @(posedge clk); #1; rst_n = 1'b1;

    // R7/R1: empty windows.
    clear_arrays(); run_vec("R7 empty");

    // R3: equal sequence numbers, lower class code first.
    clear_arrays(); load(1, 1, 5, 0); load(0, 1, 5, 0); load(4, 1, 3, 0);
    run_vec("R3 tie");
    tests++; if (e_cls[1] != 0) fail_line("R3 tie model", e_cls[1], 0);

    // R2: integer cap leaves room for younger misc.
    clear_arrays(); load(0, 4, 1, 0); load(4, 4, 10, 0); run_vec("R2 int cap");

    // R10: squashed integer entry behind the exhausted limit stays.
    clear_arrays(); load(0, 4, 1, 4'b0100); run_vec("R10 cap then squash");
    tests++; if (int'(pop_cnt[0 +: PW]) != 2) fail_line("R10 int pop", int'(pop_cnt[0 +: PW]), 2);

    // R4: two squashed float entries dropped ahead of a live one.
    clear_arrays(); load(1, 3, 7, 4'b0011); load(2, 1, 20, 0); run_vec("R4 squash drop");

    // R5: drain ignores squash flags and has no class cap.
    clear_arrays(); load(5, 4, 1, 4'b1111); load(0, 2, 50, 0); run_vec("R5 drain");
    tests++; if (int'(pop_cnt[5*PW +: PW]) != 4) fail_line("R5 drain pop", int'(pop_cnt[5*PW +: PW]), 4);

    // R8: memory cap and notification.
    clear_arrays(); load(3, 2, 1, 0); run_vec("R8 mem");
    tests++; if (mem_notify != 1'b1) fail_line("R8 notify high", int'(mem_notify), 1);

    // R1/R6: more eligible than width, mixed classes.
    clear_arrays(); load(4, 4, 2, 0); load(5, 4, 1, 0); load(2, 2, 0, 0); run_vec("R1 R6 full width");

    // Random mix: R1 R2 R3 R4 R5 R6 R7 R8.
    for (int i = 0; i < 400; i++) begin
      clear_arrays();
      for (int c = 0; c < NC; c++) begin
        int n;
        n = $urandom_range(0, WIN);
        for (int w = 0; w < n; w++) begin
          v[c][w] = 1;
          q[c][w] = ($urandom % 10) < 3;
          sq_n[c][w] = (i % 2 == 0) ? int'($urandom % 16) : int'($urandom % 256);
        end
      end
      run_vec("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule